// File: doc/BRIEF.md
# Two-Bank Interleaved Dual-Request Data Array

This block gives two load/store request channels access, in the same cycle, to one word-addressed data array. The array is made of two single-ported synchronous banks. Words with an even address sit in one bank and words with an odd address sit in the other. Each channel's request is routed to the bank named by its word-address parity, and the address, write data and read data all cross over between channels and banks.

When the two requests target different banks, both are serviced in the same cycle. When they target the same bank, one request waits for one cycle. Channel 0 normally wins the bank. A channel 1 request that was held gets the bank on the following cycle, so channel 1 cannot be starved. Read data comes back on the channel that issued the read, one cycle after that read is accepted.

Each channel uses a valid/ready handshake. A request counts as accepted in a cycle where both valid and ready are high.

Top module: `dbank_port_arb`

## Requirements
- R1: The word at address A is stored in bank A[0], in row A[ADDR_W-1:1]. Bank 0 holds even words and bank 1 holds odd words. Two different addresses never share storage.
- R2: If both channels are valid in a cycle and their address bit 0 differs, both ready outputs are high and both requests are accepted in that cycle.
- R3: If both channels are valid and target the same bank, and channel 1 was not held in the previous cycle, then channel 0 is accepted and `ch1_ready_o` is low.
- R4: A channel 1 request that was held in one cycle is accepted in the next cycle, provided it is still presented unchanged. If channel 0 targets the same bank in that cycle, `ch0_ready_o` is low instead.
- R5: An accepted read raises that channel's `rsp_valid` exactly one cycle later, with the read data. An accepted write produces no response, and a cycle with no accepted read leaves `rsp_valid` low on the next cycle.
- R6: If both channels write the same word in one cycle, channel 0's write is applied first and channel 1's write is applied second. The word ends up holding channel 1's data.
- R7: Accesses take effect in acceptance order, with channel 0 ahead of channel 1 within a cycle. A read returns the most recent write accepted before it, including a channel 0 write to the same word that caused the read to be held.
- R8: During reset and on the first cycle after it, both `rsp_valid` outputs are low and both ready outputs are high. No hold priority is pending after reset.
- R9: A channel whose valid input is low never lowers the other channel's ready output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch0_valid_i | input | 1 | Channel 0 request valid |
| ch0_ready_o | output | 1 | Channel 0 request accepted this cycle |
| ch0_we_i | input | 1 | Channel 0 write (1) or read (0) |
| ch0_addr_i | input | ADDR_W | Channel 0 word address; bit 0 selects the bank |
| ch0_wdata_i | input | DATA_W | Channel 0 write data |
| ch0_rsp_valid_o | output | 1 | Channel 0 read data valid |
| ch0_rsp_rdata_o | output | DATA_W | Channel 0 read data |
| ch1_valid_i | input | 1 | Channel 1 request valid |
| ch1_ready_o | output | 1 | Channel 1 request accepted this cycle |
| ch1_we_i | input | 1 | Channel 1 write (1) or read (0) |
| ch1_addr_i | input | ADDR_W | Channel 1 word address; bit 0 selects the bank |
| ch1_wdata_i | input | DATA_W | Channel 1 write data |
| ch1_rsp_valid_o | output | 1 | Channel 1 read data valid |
| ch1_rsp_rdata_o | output | DATA_W | Channel 1 read data |

## Verification
The properties assume that each requester follows the handshake. A request that is valid but not ready stays valid with the same address, write enable and data until it is accepted. The no-starvation check on channel 1 depends on this, because the held request must still be present on the next cycle. The bench holds every refused request unchanged and issues a new request on a channel only after its previous one was accepted. Random traffic uses a small address window to force frequent same-bank collisions. The bench compares every read response against a flat memory model that applies accepted writes in channel 0, then channel 1 order.

// File: rtl/dbank_pkg.sv
package dbank_pkg;
  localparam int NUM_CH   = 2;
  localparam int NUM_BANK = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CH0  = 2'd1,
    SRC_CH1  = 2'd2
  } bank_src_e;
endpackage

// File: rtl/dbank_ram.sv
module dbank_ram #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 256,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[row_i] <= wdata_i;
      else      rdata_o      <= mem_q[row_i];
    end
  end
endmodule

// File: rtl/dbank_conflict_arb.sv
module dbank_conflict_arb
  import dbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_v_i,
  input  logic [NUM_CH-1:0] bank_i,
  output logic [NUM_CH-1:0] ready_o,
  output logic [NUM_CH-1:0] gnt_o
);
  logic conflict;
  logic ch1_hold_q; // ch1 was refused last cycle and now takes priority

  assign conflict   = req_v_i[0] & req_v_i[1] & (bank_i[0] == bank_i[1]);
  assign ready_o[0] = ~(conflict & ch1_hold_q);
  assign ready_o[1] = ~(conflict & ~ch1_hold_q);
  assign gnt_o      = req_v_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ch1_hold_q <= 1'b0;
    else         ch1_hold_q <= conflict & ~ch1_hold_q;
  end
endmodule

// File: rtl/dbank_xbar.sv
module dbank_xbar
  import dbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ROW_W  = 8
) (
  input  logic [NUM_CH-1:0]               gnt_i,
  input  logic [NUM_CH-1:0]               bank_i,
  input  logic [NUM_CH-1:0]               we_i,
  input  logic [NUM_CH-1:0][ROW_W-1:0]    row_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]   wdata_i,
  output logic [NUM_BANK-1:0]             en_o,
  output logic [NUM_BANK-1:0]             we_o,
  output logic [NUM_BANK-1:0][ROW_W-1:0]  row_o,
  output logic [NUM_BANK-1:0][DATA_W-1:0] wdata_o
);
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    bank_src_e src;

    always_comb begin
      if (gnt_i[0] && bank_i[0] == 1'(b))      src = SRC_CH0;
      else if (gnt_i[1] && bank_i[1] == 1'(b)) src = SRC_CH1;
      else                                     src = SRC_NONE;
    end

    always_comb begin
      en_o[b]    = 1'b0;
      we_o[b]    = 1'b0;
      row_o[b]   = '0;
      wdata_o[b] = '0;
      unique case (src)
        SRC_CH0: begin
          en_o[b]    = 1'b1;
          we_o[b]    = we_i[0];
          row_o[b]   = row_i[0];
          wdata_o[b] = wdata_i[0];
        end
        SRC_CH1: begin
          en_o[b]    = 1'b1;
          we_o[b]    = we_i[1];
          row_o[b]   = row_i[1];
          wdata_o[b] = wdata_i[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dbank_rsp_steer.sv
module dbank_rsp_steer
  import dbank_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CH-1:0]                rd_gnt_i,
  input  logic [NUM_CH-1:0]                bank_i,
  input  logic [NUM_BANK-1:0][DATA_W-1:0]  bank_rdata_i,
  output logic [NUM_CH-1:0]                rsp_valid_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]    rsp_rdata_o
);
  logic [NUM_CH-1:0] rsp_bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= '0;
      rsp_bank_q  <= '0;
    end else begin
      rsp_valid_o <= rd_gnt_i;
      rsp_bank_q  <= bank_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rsp_rdata_o[c] = bank_rdata_i[rsp_bank_q[c]];
  end
endmodule

// File: rtl/dbank_port_arb.sv
module dbank_port_arb
  import dbank_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int BANK_DEPTH = 256,
  localparam int ROW_W     = $clog2(BANK_DEPTH),
  localparam int ADDR_W    = ROW_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ch0_valid_i,
  output logic              ch0_ready_o,
  input  logic              ch0_we_i,
  input  logic [ADDR_W-1:0] ch0_addr_i,
  input  logic [DATA_W-1:0] ch0_wdata_i,
  output logic              ch0_rsp_valid_o,
  output logic [DATA_W-1:0] ch0_rsp_rdata_o,
  input  logic              ch1_valid_i,
  output logic              ch1_ready_o,
  input  logic              ch1_we_i,
  input  logic [ADDR_W-1:0] ch1_addr_i,
  input  logic [DATA_W-1:0] ch1_wdata_i,
  output logic              ch1_rsp_valid_o,
  output logic [DATA_W-1:0] ch1_rsp_rdata_o
);
  logic [NUM_CH-1:0]               req_v, req_we, bank_sel, ready, gnt;
  logic [NUM_CH-1:0][ROW_W-1:0]    req_row;
  logic [NUM_CH-1:0][DATA_W-1:0]   req_wdata, rsp_rdata;
  logic [NUM_CH-1:0]               rsp_valid;
  logic [NUM_BANK-1:0]             b_en, b_we;
  logic [NUM_BANK-1:0][ROW_W-1:0]  b_row;
  logic [NUM_BANK-1:0][DATA_W-1:0] b_wdata, b_rdata;

  assign req_v     = {ch1_valid_i, ch0_valid_i};
  assign req_we    = {ch1_we_i, ch0_we_i};
  assign bank_sel  = {ch1_addr_i[0], ch0_addr_i[0]};
  assign req_row   = {ch1_addr_i[ADDR_W-1:1], ch0_addr_i[ADDR_W-1:1]};
  assign req_wdata = {ch1_wdata_i, ch0_wdata_i};

  dbank_conflict_arb u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_v_i (req_v),
    .bank_i  (bank_sel),
    .ready_o (ready),
    .gnt_o   (gnt)
  );

  dbank_xbar #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_xbar (
    .gnt_i   (gnt),
    .bank_i  (bank_sel),
    .we_i    (req_we),
    .row_i   (req_row),
    .wdata_i (req_wdata),
    .en_o    (b_en),
    .we_o    (b_we),
    .row_o   (b_row),
    .wdata_o (b_wdata)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_ram
    dbank_ram #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_ram (
      .clk_i   (clk_i),
      .en_i    (b_en[b]),
      .we_i    (b_we[b]),
      .row_i   (b_row[b]),
      .wdata_i (b_wdata[b]),
      .rdata_o (b_rdata[b])
    );
  end

  dbank_rsp_steer #(.DATA_W(DATA_W)) u_rsp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_gnt_i     (gnt & ~req_we),
    .bank_i       (bank_sel),
    .bank_rdata_i (b_rdata),
    .rsp_valid_o  (rsp_valid),
    .rsp_rdata_o  (rsp_rdata)
  );

  assign ch0_ready_o     = ready[0];
  assign ch1_ready_o     = ready[1];
  assign ch0_rsp_valid_o = rsp_valid[0];
  assign ch1_rsp_valid_o = rsp_valid[1];
  assign ch0_rsp_rdata_o = rsp_rdata[0];
  assign ch1_rsp_rdata_o = rsp_rdata[1];
endmodule

// File: rtl/dbank_port_arb_chk.sv
module dbank_port_arb_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ch0_valid_i,
  input logic              ch0_ready_o,
  input logic              ch0_we_i,
  input logic [ADDR_W-1:0] ch0_addr_i,
  input logic              ch0_rsp_valid_o,
  input logic              ch1_valid_i,
  input logic              ch1_ready_o,
  input logic              ch1_we_i,
  input logic [ADDR_W-1:0] ch1_addr_i,
  input logic              ch1_rsp_valid_o
);
  logic same_bank;
  assign same_bank = ch0_addr_i[0] == ch1_addr_i[0];

  // R2
  split_bank_dual_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch0_valid_i && ch1_valid_i && !same_bank) |-> (ch0_ready_o && ch1_ready_o));

  // R3
  conflict_single_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch0_valid_i && ch1_valid_i && same_bank) |-> (ch0_ready_o != ch1_ready_o));

  // R4
  held_ch1_next_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch1_valid_i && !ch1_ready_o) |=> ch1_ready_o);

  // R4
  ch0_stall_only_after_ch1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch0_ready_o |-> $past(ch1_valid_i && !ch1_ready_o));

  // R5
  ch0_read_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch0_valid_i && ch0_ready_o && !ch0_we_i) |=> ch0_rsp_valid_o);

  // R5
  ch1_rsp_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch1_rsp_valid_o |-> $past(ch1_valid_i && ch1_ready_o && !ch1_we_i));

  // R9
  idle_ch0_no_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch0_valid_i |-> ch1_ready_o);

  // R9
  idle_ch1_no_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch1_valid_i |-> ch0_ready_o);
endmodule

bind dbank_port_arb dbank_port_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ch0_valid_i     (ch0_valid_i),
  .ch0_ready_o     (ch0_ready_o),
  .ch0_we_i        (ch0_we_i),
  .ch0_addr_i      (ch0_addr_i),
  .ch0_rsp_valid_o (ch0_rsp_valid_o),
  .ch1_valid_i     (ch1_valid_i),
  .ch1_ready_o     (ch1_ready_o),
  .ch1_we_i        (ch1_we_i),
  .ch1_addr_i      (ch1_addr_i),
  .ch1_rsp_valid_o (ch1_rsp_valid_o)
);

// File: tb/dbank_port_arb_tb.sv
`timescale 1ns/1ps
module dbank_port_arb_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ch0_valid_i = 1'b0, ch0_we_i = 1'b0, ch1_valid_i = 1'b0, ch1_we_i = 1'b0;
  logic [8:0]  ch0_addr_i = '0, ch1_addr_i = '0;
  logic [63:0] ch0_wdata_i = '0, ch1_wdata_i = '0;
  logic        ch0_ready_o, ch1_ready_o, ch0_rsp_valid_o, ch1_rsp_valid_o;
  logic [63:0] ch0_rsp_rdata_o, ch1_rsp_rdata_o;

  int errs = 0, checks = 0, stalls = 0;
  logic [63:0] model [512];

  always #2.5 clk_i = ~clk_i;

  dbank_port_arb u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample ready after settling, check responses next negedge
  task automatic step(input bit v0, input bit we0, input logic [8:0] a0, input logic [63:0] d0,
                      input bit v1, input bit we1, input logic [8:0] a1, input logic [63:0] d1,
                      output bit acc0, output bit acc1);
    logic [63:0] x0, x1;
    bit e0, e1;
    ch0_valid_i = v0; ch0_we_i = we0; ch0_addr_i = a0; ch0_wdata_i = d0;
    ch1_valid_i = v1; ch1_we_i = we1; ch1_addr_i = a1; ch1_wdata_i = d1;
    #1;
    acc0 = v0 && ch0_ready_o;
    acc1 = v1 && ch1_ready_o;
    if ((v0 && !ch0_ready_o) || (v1 && !ch1_ready_o)) stalls++;
    e0 = acc0 && !we0;
    e1 = acc1 && !we1;
    x0 = '0; x1 = '0;
    if (acc0) begin if (we0) model[a0] = d0; else x0 = model[a0]; end
    if (acc1) begin if (we1) model[a1] = d1; else x1 = model[a1]; end
    @(posedge clk_i); @(negedge clk_i);
    chk(ch0_rsp_valid_o === e0, "R5 ch0 rsp_valid", 64'(ch0_rsp_valid_o), 64'(e0));
    chk(ch1_rsp_valid_o === e1, "R5 ch1 rsp_valid", 64'(ch1_rsp_valid_o), 64'(e1));
    if (e0) chk(ch0_rsp_rdata_o === x0, "R7 ch0 rdata", ch0_rsp_rdata_o, x0);
    if (e1) chk(ch1_rsp_rdata_o === x1, "R7 ch1 rdata", ch1_rsp_rdata_o, x1);
  endtask

  task automatic idle();
    bit a, b;
    step(0, 0, 0, 0, 0, 0, 0, 0, a, b);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(ch0_rsp_valid_o === 1'b0 && ch1_rsp_valid_o === 1'b0, "R8 rsp in reset",
        {ch0_rsp_valid_o, ch1_rsp_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ch0_ready_o === 1'b1 && ch1_ready_o === 1'b1, "R8 ready after reset",
        {ch0_ready_o, ch1_ready_o}, 2'b11);
    chk(ch0_rsp_valid_o === 1'b0 && ch1_rsp_valid_o === 1'b0, "R8 rsp after reset",
        {ch0_rsp_valid_o, ch1_rsp_valid_o}, 0);
  endtask

  task automatic t_parallel();
    bit a0, a1;
    step(1, 1, 9'd4, 64'hAAAA_0004, 1, 1, 9'd5, 64'hBBBB_0005, a0, a1);
    chk(a0 && a1, "R2 split-bank writes both accepted", {a0, a1}, 2'b11);
    step(1, 1, 9'd6, 64'hCCCC_0006, 1, 1, 9'd7, 64'hDDDD_0007, a0, a1);
    step(1, 0, 9'd5, 0, 1, 0, 9'd4, 0, a0, a1);
    chk(a0 && a1, "R2 split-bank reads both accepted", {a0, a1}, 2'b11);
    chk(ch0_rsp_rdata_o === 64'hBBBB_0005, "R1 odd word from bank 1", ch0_rsp_rdata_o, 64'hBBBB_0005);
    chk(ch1_rsp_rdata_o === 64'hAAAA_0004, "R1 even word from bank 0", ch1_rsp_rdata_o, 64'hAAAA_0004);
    step(1, 0, 9'd7, 0, 1, 0, 9'd6, 0, a0, a1);
  endtask

  task automatic t_conflict();
    bit a0, a1;
    step(1, 0, 9'd4, 0, 1, 0, 9'd6, 0, a0, a1);
    chk(a0 && !a1, "R3 ch0 wins same bank", {a0, a1}, 2'b10);
    step(1, 0, 9'd8, 0, 1, 0, 9'd6, 0, a0, a1);
    chk(!a0 && a1, "R4 held ch1 wins next cycle", {a0, a1}, 2'b01);
    step(1, 0, 9'd8, 0, 0, 0, 0, 0, a0, a1);
    chk(a0, "R4 ch0 accepted after yielding", 64'(a0), 1);
  endtask

  task automatic t_same_word_write();
    bit a0, a1;
    step(1, 1, 9'd10, 64'h1111, 1, 1, 9'd10, 64'h2222, a0, a1);
    chk(a0 && !a1, "R6 ch0 write goes first", {a0, a1}, 2'b10);
    step(0, 0, 0, 0, 1, 1, 9'd10, 64'h2222, a0, a1);
    chk(a1, "R6 ch1 write lands second", 64'(a1), 1);
    step(1, 0, 9'd10, 0, 0, 0, 0, 0, a0, a1);
    chk(ch0_rsp_rdata_o === 64'h2222, "R6 final value is ch1 data", ch0_rsp_rdata_o, 64'h2222);
  endtask

  task automatic t_raw();
    bit a0, a1;
    step(1, 0, 9'd20, 0, 0, 0, 0, 0, a0, a1);
    step(1, 1, 9'd20, 64'h5A5A_0020, 1, 0, 9'd20, 0, a0, a1);
    step(0, 0, 0, 0, 1, 0, 9'd20, 0, a0, a1);
    chk(ch1_rsp_rdata_o === 64'h5A5A_0020, "R7 held read sees ch0 write", ch1_rsp_rdata_o,
        64'h5A5A_0020);
  endtask

  task automatic t_idle_and_write();
    bit a0, a1;
    step(0, 0, 0, 0, 1, 0, 9'd20, 0, a0, a1);
    chk(a1, "R9 idle ch0 never blocks ch1", 64'(a1), 1);
    step(1, 1, 9'd3, 64'h33, 0, 0, 9'd3, 0, a0, a1);
    chk(a0, "R9 idle ch1 never blocks ch0", 64'(a0), 1);
    chk(ch0_rsp_valid_o === 1'b0, "R5 write gives no response", 64'(ch0_rsp_valid_o), 0);
  endtask

  task automatic t_random();
    bit pv0 = 0, pv1 = 0, pw0, pw1, a0, a1, held1 = 0;
    logic [8:0] pa0, pa1;
    logic [63:0] pd0, pd1;
    int s0 = stalls;
    for (int i = 0; i < 3000; i++) begin
      if (!pv0 && ($urandom % 4 != 0)) begin
        pv0 = 1; pw0 = $urandom % 2; pa0 = 9'($urandom % 24); pd0 = {$urandom, $urandom};
      end
      if (!pv1 && ($urandom % 4 != 0)) begin
        pv1 = 1; pw1 = $urandom % 2; pa1 = 9'($urandom % 24); pd1 = {$urandom, $urandom};
      end
      step(pv0, pw0, pa0, pd0, pv1, pw1, pa1, pd1, a0, a1);
      if (held1) chk(a1, "R4 random held ch1 accepted", 64'(a1), 1);
      held1 = pv1 && !a1;
      if (pv0 && pv1 && (pa0[0] != pa1[0])) chk(a0 && a1, "R2 random split banks", {a0, a1}, 2'b11);
      if (a0) pv0 = 0;
      if (a1) pv1 = 0;
    end
    $display("random traffic conflict stalls: %0d", stalls - s0);
    chk(stalls - s0 > 0, "R3 random traffic hit conflicts", 64'(stalls - s0), 1);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) model[i] = '0;
    // prime memory so reads never see uninitialised rows
    repeat (2) @(negedge clk_i);
    t_reset();
    for (int i = 0; i < 256; i++) begin
      bit a, b;
      step(1, 1, 9'(2 * i), 64'(2 * i), 1, 1, 9'(2 * i + 1), 64'(2 * i + 1), a, b);
    end
    t_parallel();
    t_conflict();
    t_same_word_write();
    t_raw();
    t_idle_and_write();
    t_random();
    idle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #500000;
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule